// File: doc/BRIEF.md
# Dual-Issue Instruction Pair Classifier

This block sits in the dispatch stage of a mostly scalar pipeline that can fold a simple second instruction into the one ahead of it. Each cycle it receives two pre-decoded instruction descriptors in program order, a primary and a secondary. Each descriptor carries an opcode class, an operand size, destination and source register numbers, a source operand kind, a flag for a memory destination and, for the secondary, its length in 16-bit words.

The classifier checks the pair against three fixed folding patterns. The first is load folding: a longword move feeds an ALU operation on the same register. The second is store folding: a store is paired with a simple register load. The third is address-result folding: a primary whose result comes from the address-generation unit is paired with a simple secondary that runs in the execute unit. The patterns are tried in a fixed priority. On the clock edge after a valid pair, the block registers whether the pair issues together, which group applies, and the merged operand and unit selects for the next stage. Anything that does not match a pattern leaves the secondary to issue by itself later.

Top module: `pair_classify`

## Requirements
Encodings: class 0 other, 1 move, 2 clear, 3 load-effective-address, 4 move-quick, 5 3-bit quick move, 6 ALU, 7 compare. Size 0 byte, 1 word, 2 longword, 3 reserved. Operand kind 0 register, 1 quick immediate, 2 immediate, 3 memory. Group code 0 none, 1 load, 2 store, 3 address. Secondary unit 0 none, 1 ALU, 2 shifter pass-operand-2.
- R1: While reset is asserted, every output is zero.
- R2: A pair is rejected (group 0) unless the secondary is exactly SEC_LEN words long (default 1), its source kind is not memory and its memory-destination flag is clear.
- R3: Group 1 is selected when all of the following hold. The primary is a longword move with a clear memory-destination flag and a register or memory source. The secondary is a longword ALU operation with a register or quick-immediate source and the same destination register as the primary.
- R4: For group 1, the merged destination is the primary destination and the secondary unit is ALU. Operand 1 carries the primary source kind and register, operand 2 carries the secondary source kind and register, and the store and address flags are 0.
- R5: Group 2 is selected when both of the following hold. The primary has its memory-destination flag set, a byte, word or longword size, and is either a move with a register source or a clear. The secondary is either a longword move with a register source or a move-quick.
- R6: For group 2, the secondary unit is the shifter pass-operand-2 code (2), the store flag is 1, the address flag is 0, and the merged destination is the secondary destination.
- R7: Group 3 is selected when both of the following hold, and the address flag is then 1. The primary has a clear memory-destination flag and is one of: load-effective-address, a longword move with an immediate source, a move-quick, a longword clear, or a 3-bit quick move. The secondary is one of: a longword ALU operation with a register or quick-immediate source, a longword move with a register source, a move-quick, or a longword compare with a register source.
- R8: With BYPASS_EN=0, group 3 is refused when the secondary reads the primary destination. This happens when the secondary source kind is register and its source equals the primary destination, or when the secondary is ALU or compare and its destination equals the primary destination.
- R9: Outputs update on the clock edge after the inputs are presented. With in_valid low, the next state has pair_valid 0 and group 0. pair_valid is 1 exactly when the group code is non-zero.
- R10: flush high forces pair_valid, the group and all merged fields to zero on the next edge, whatever the other inputs are.
- R11: When no pair issues, every merged field (destination, operand kinds and registers, unit, store and address flags) is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard the pair being classified |
| in_valid | input | 1 | Descriptors are valid this cycle |
| p_cls | input | 3 | Primary opcode class |
| p_size | input | 2 | Primary operand size |
| p_dst | input | REG_W | Primary destination register |
| p_src | input | REG_W | Primary source register |
| p_okind | input | 2 | Primary source kind |
| p_dmem | input | 1 | Primary writes memory |
| s_cls | input | 3 | Secondary opcode class |
| s_size | input | 2 | Secondary operand size |
| s_dst | input | REG_W | Secondary destination register |
| s_src | input | REG_W | Secondary source register |
| s_okind | input | 2 | Secondary source kind |
| s_dmem | input | 1 | Secondary writes memory |
| s_len | input | LEN_W | Secondary length in 16-bit words |
| pair_valid | output | 1 | Pair issues together |
| pair_grp | output | 2 | Pairing group code |
| m_dst | output | REG_W | Merged destination register |
| m_op1_kind | output | 2 | Operand 1 kind |
| m_op1_reg | output | REG_W | Operand 1 register |
| m_op2_kind | output | 2 | Operand 2 kind |
| m_op2_reg | output | REG_W | Operand 2 register |
| m_sec_unit | output | 2 | Execute unit for the secondary |
| m_store | output | 1 | Concurrent store from operand 1 path |
| m_pri_agen | output | 1 | Primary result from address unit |

## Verification
The bench builds the block with its defaults: REG_W=4, LEN_W=2, SEC_LEN=1 and BYPASS_EN=0. With the bypass off, the read-after-write refusal of group 3 is reachable and can be checked against both the source-register path and the destination-read path. With sixteen registers, random descriptors often hit register equality between the two instructions, so destination matches for group 1 and hazards for group 3 come up repeatedly. The two-bit length field lets lengths of 0, 2 and 3 words show the length gate rejecting secondaries.

// File: rtl/pair_pkg.sv
package pair_pkg;

   typedef enum logic [2:0] {
      OPC_OTHER = 3'd0,
      OPC_MOVE  = 3'd1,
      OPC_CLR   = 3'd2,
      OPC_LEA   = 3'd3,
      OPC_MOVQ  = 3'd4,
      OPC_MOV3Q = 3'd5,
      OPC_ALU   = 3'd6,
      OPC_CMP   = 3'd7
   } opc_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2,
      SZ_RSV  = 2'd3
   } size_e;

   typedef enum logic [1:0] {
      OK_REG  = 2'd0,
      OK_QIMM = 2'd1,
      OK_IMM  = 2'd2,
      OK_MEM  = 2'd3
   } okind_e;

   typedef enum logic [1:0] {
      GRP_NONE  = 2'd0,
      GRP_LOAD  = 2'd1,
      GRP_STORE = 2'd2,
      GRP_ADDR  = 2'd3
   } grp_e;

   typedef enum logic [1:0] {
      SU_NONE   = 2'd0,
      SU_ALU    = 2'd1,
      SU_SHPASS = 2'd2,
      SU_RSV    = 2'd3
   } unit_e;

endpackage

// File: rtl/pair_sec_gate.sv
module pair_sec_gate #(
   parameter int LEN_W   = 2,
   parameter int SEC_LEN = 1
) (
   input  logic [1:0]       s_okind,
   input  logic             s_dmem,
   input  logic [LEN_W-1:0] s_len,
   output logic             sec_ok
);
   import pair_pkg::*;

   localparam logic [LEN_W-1:0] SEC_LEN_V = LEN_W'(SEC_LEN);

   if (LEN_W < 1) begin : g_bad_len_w
      $error("pair_sec_gate: LEN_W must be at least 1");
   end
   if (SEC_LEN < 1 || SEC_LEN >= (1 << LEN_W)) begin : g_bad_sec_len
      $error("pair_sec_gate: SEC_LEN must fit in LEN_W and be non-zero");
   end

   logic len_ok;
   logic no_mem;

   always_comb begin
      len_ok = (s_len == SEC_LEN_V);
      no_mem = (s_okind != OK_MEM) && !s_dmem;
      sec_ok = len_ok && no_mem;
   end

endmodule

// File: rtl/pair_grp_match.sv
module pair_grp_match #(
   parameter int REG_W     = 4,
   parameter bit BYPASS_EN = 1'b0
) (
   input  logic             sec_ok,
   input  logic [2:0]       p_cls,
   input  logic [1:0]       p_size,
   input  logic [REG_W-1:0] p_dst,
   input  logic [1:0]       p_okind,
   input  logic             p_dmem,
   input  logic [2:0]       s_cls,
   input  logic [1:0]       s_size,
   input  logic [REG_W-1:0] s_dst,
   input  logic [REG_W-1:0] s_src,
   input  logic [1:0]       s_okind,
   output logic [1:0]       grp
);
   import pair_pkg::*;

   if (REG_W < 1) begin : g_bad_reg_w
      $error("pair_grp_match: REG_W must be at least 1");
   end

   // primary shapes
   logic p_long, p_mv_long, p_src_reg, p_src_regmem, p_sized;
   // secondary shapes
   logic s_long, s_src_reg, s_src_rq, s_alu_l, s_mv_rr, s_movq, s_cmp_rr;
   // per-group candidates
   logic g1_hit, g2_pri, g2_sec, g3_pri, g3_sec, g3_haz;

   always_comb begin
      p_long       = (p_size == SZ_LONG);
      p_sized      = (p_size != SZ_RSV);
      p_mv_long    = (p_cls == OPC_MOVE) && p_long;
      p_src_reg    = (p_okind == OK_REG);
      p_src_regmem = (p_okind == OK_REG) || (p_okind == OK_MEM);

      s_long    = (s_size == SZ_LONG);
      s_src_reg = (s_okind == OK_REG);
      s_src_rq  = (s_okind == OK_REG) || (s_okind == OK_QIMM);
      s_alu_l   = (s_cls == OPC_ALU) && s_long && s_src_rq;
      s_mv_rr   = (s_cls == OPC_MOVE) && s_long && s_src_reg;
      s_movq    = (s_cls == OPC_MOVQ);
      s_cmp_rr  = (s_cls == OPC_CMP) && s_long && s_src_reg;
   end

   // Group 1: longword move into Rx feeding an ALU op on Rx
   always_comb begin
      g1_hit = p_mv_long && !p_dmem && p_src_regmem && s_alu_l && (s_dst == p_dst);
   end

   // Group 2: store paired with a simple register load
   always_comb begin
      g2_pri = p_dmem && p_sized &&
               (((p_cls == OPC_MOVE) && p_src_reg) || (p_cls == OPC_CLR));
      g2_sec = s_mv_rr || s_movq;
   end

   // Group 3: address-unit result paired with an execute-unit op
   always_comb begin
      g3_pri = !p_dmem &&
               ((p_cls == OPC_LEA) ||
                (p_mv_long && (p_okind == OK_IMM)) ||
                (p_cls == OPC_MOVQ) ||
                ((p_cls == OPC_CLR) && p_long) ||
                (p_cls == OPC_MOV3Q));
      g3_sec = s_alu_l || s_mv_rr || s_movq || s_cmp_rr;
   end

   if (BYPASS_EN) begin : g_bypass
      assign g3_haz = 1'b0;
   end else begin : g_interlock
      logic rd_src, rd_dst;
      always_comb begin
         rd_src = s_src_reg && (s_src == p_dst);
         rd_dst = ((s_cls == OPC_ALU) || (s_cls == OPC_CMP)) && (s_dst == p_dst);
      end
      assign g3_haz = rd_src || rd_dst;
   end

   // fixed priority: load, then store, then address
   always_comb begin
      grp = GRP_NONE;
      if (sec_ok) begin
         if (g1_hit)                         grp = GRP_LOAD;
         else if (g2_pri && g2_sec)          grp = GRP_STORE;
         else if (g3_pri && g3_sec && !g3_haz) grp = GRP_ADDR;
      end
   end

endmodule

// File: rtl/pair_merge.sv
module pair_merge #(
   parameter int REG_W = 4
) (
   input  logic [1:0]       grp,
   input  logic [REG_W-1:0] p_dst,
   input  logic [REG_W-1:0] p_src,
   input  logic [1:0]       p_okind,
   input  logic [REG_W-1:0] s_dst,
   input  logic [REG_W-1:0] s_src,
   input  logic [1:0]       s_okind,
   output logic [REG_W-1:0] dst,
   output logic [1:0]       op1_kind,
   output logic [REG_W-1:0] op1_reg,
   output logic [1:0]       op2_kind,
   output logic [REG_W-1:0] op2_reg,
   output logic [1:0]       sec_unit,
   output logic             store,
   output logic             pri_agen
);
   import pair_pkg::*;

   always_comb begin
      dst      = '0;
      op1_kind = '0;
      op1_reg  = '0;
      op2_kind = '0;
      op2_reg  = '0;
      sec_unit = SU_NONE;
      store    = 1'b0;
      pri_agen = 1'b0;
      unique case (grp)
         GRP_LOAD: begin
            dst      = p_dst;
            sec_unit = SU_ALU;
         end
         GRP_STORE: begin
            dst      = s_dst;
            sec_unit = SU_SHPASS;
            store    = 1'b1;
         end
         GRP_ADDR: begin
            dst      = s_dst;
            sec_unit = SU_ALU;
            pri_agen = 1'b1;
         end
         default: ;
      endcase
      if (grp != GRP_NONE) begin
         op1_kind = p_okind;
         op1_reg  = p_src;
         op2_kind = s_okind;
         op2_reg  = s_src;
      end
   end

endmodule

// File: rtl/pair_classify.sv
module pair_classify #(
   parameter int REG_W     = 4,
   parameter int LEN_W     = 2,
   parameter int SEC_LEN   = 1,
   parameter bit BYPASS_EN = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             in_valid,
   input  logic [2:0]       p_cls,
   input  logic [1:0]       p_size,
   input  logic [REG_W-1:0] p_dst,
   input  logic [REG_W-1:0] p_src,
   input  logic [1:0]       p_okind,
   input  logic             p_dmem,
   input  logic [2:0]       s_cls,
   input  logic [1:0]       s_size,
   input  logic [REG_W-1:0] s_dst,
   input  logic [REG_W-1:0] s_src,
   input  logic [1:0]       s_okind,
   input  logic             s_dmem,
   input  logic [LEN_W-1:0] s_len,
   output logic             pair_valid,
   output logic [1:0]       pair_grp,
   output logic [REG_W-1:0] m_dst,
   output logic [1:0]       m_op1_kind,
   output logic [REG_W-1:0] m_op1_reg,
   output logic [1:0]       m_op2_kind,
   output logic [REG_W-1:0] m_op2_reg,
   output logic [1:0]       m_sec_unit,
   output logic             m_store,
   output logic             m_pri_agen
);
   import pair_pkg::*;

   localparam logic [LEN_W-1:0] SEC_LEN_V = LEN_W'(SEC_LEN);

   if (REG_W < 1 || REG_W > 8) begin : g_bad_reg_w
      $error("pair_classify: REG_W must be between 1 and 8");
   end

   logic             sec_ok;
   logic [1:0]       grp_c;
   logic [REG_W-1:0] dst_c, op1_reg_c, op2_reg_c;
   logic [1:0]       op1_kind_c, op2_kind_c, sec_unit_c;
   logic             store_c, agen_c;
   logic             take;

   pair_sec_gate #(.LEN_W(LEN_W), .SEC_LEN(SEC_LEN)) i_gate (
      .s_okind (s_okind),
      .s_dmem  (s_dmem),
      .s_len   (s_len),
      .sec_ok  (sec_ok)
   );

   pair_grp_match #(.REG_W(REG_W), .BYPASS_EN(BYPASS_EN)) i_match (
      .sec_ok  (sec_ok),
      .p_cls   (p_cls),
      .p_size  (p_size),
      .p_dst   (p_dst),
      .p_okind (p_okind),
      .p_dmem  (p_dmem),
      .s_cls   (s_cls),
      .s_size  (s_size),
      .s_dst   (s_dst),
      .s_src   (s_src),
      .s_okind (s_okind),
      .grp     (grp_c)
   );

   pair_merge #(.REG_W(REG_W)) i_merge (
      .grp      (grp_c),
      .p_dst    (p_dst),
      .p_src    (p_src),
      .p_okind  (p_okind),
      .s_dst    (s_dst),
      .s_src    (s_src),
      .s_okind  (s_okind),
      .dst      (dst_c),
      .op1_kind (op1_kind_c),
      .op1_reg  (op1_reg_c),
      .op2_kind (op2_kind_c),
      .op2_reg  (op2_reg_c),
      .sec_unit (sec_unit_c),
      .store    (store_c),
      .pri_agen (agen_c)
   );

   always_comb take = in_valid && !flush && (grp_c != GRP_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pair_valid <= 1'b0;
         pair_grp   <= GRP_NONE;
         m_dst      <= '0;
         m_op1_kind <= '0;
         m_op1_reg  <= '0;
         m_op2_kind <= '0;
         m_op2_reg  <= '0;
         m_sec_unit <= SU_NONE;
         m_store    <= 1'b0;
         m_pri_agen <= 1'b0;
      end else if (take) begin
         pair_valid <= 1'b1;
         pair_grp   <= grp_c;
         m_dst      <= dst_c;
         m_op1_kind <= op1_kind_c;
         m_op1_reg  <= op1_reg_c;
         m_op2_kind <= op2_kind_c;
         m_op2_reg  <= op2_reg_c;
         m_sec_unit <= sec_unit_c;
         m_store    <= store_c;
         m_pri_agen <= agen_c;
      end else begin
         pair_valid <= 1'b0;
         pair_grp   <= GRP_NONE;
         m_dst      <= '0;
         m_op1_kind <= '0;
         m_op1_reg  <= '0;
         m_op2_kind <= '0;
         m_op2_reg  <= '0;
         m_sec_unit <= SU_NONE;
         m_store    <= 1'b0;
         m_pri_agen <= 1'b0;
      end
   end

   AST_ELIG_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (s_len != SEC_LEN_V || s_okind == OK_MEM || s_dmem)) |=> (pair_grp == GRP_NONE)); // R2
   AST_LOAD_UNITS: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_grp == GRP_LOAD) |-> (m_sec_unit == SU_ALU && !m_store && !m_pri_agen)); // R4
   AST_STORE_UNITS: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_grp == GRP_STORE) |-> (m_sec_unit == SU_SHPASS && m_store && !m_pri_agen)); // R6
   AST_AGEN_ONLY_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      m_pri_agen |-> (pair_grp == GRP_ADDR)); // R7
   AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!pair_valid && pair_grp == GRP_NONE)); // R9
   AST_VALID_MATCHES_GRP: assert property (@(posedge clk) disable iff (!rst_n)
      pair_valid |-> (pair_grp != GRP_NONE)); // R9
   AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!pair_valid && pair_grp == GRP_NONE && m_sec_unit == SU_NONE)); // R10
   AST_NOPAIR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !pair_valid |-> (m_dst == '0 && m_op1_reg == '0 && m_op2_reg == '0 &&
                       m_sec_unit == SU_NONE && !m_store && !m_pri_agen)); // R11

   if (!BYPASS_EN) begin : g_haz_chk
      AST_ADDR_RAW_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && s_okind == OK_REG && s_src == p_dst) |=> (pair_grp != GRP_ADDR)); // R8
   end

endmodule

// File: tb/test_pair_classify.sv
module test_pair_classify;
   localparam int CLK_PERIOD = 10;
   localparam int RW = 4;
   localparam int LW = 2;

   typedef struct {
      logic [2:0]    cls;
      logic [1:0]    sz;
      logic [RW-1:0] dst;
      logic [RW-1:0] src;
      logic [1:0]    ok;
      logic          dm;
      logic [LW-1:0] len;
   } desc_t;

   typedef struct {
      logic          v;
      logic [1:0]    g;
      logic [RW-1:0] dst;
      logic [1:0]    k1;
      logic [RW-1:0] r1;
      logic [1:0]    k2;
      logic [RW-1:0] r2;
      logic [1:0]    su;
      logic          st;
      logic          ag;
      string         tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flush = 1'b0;
   logic in_valid = 1'b0;
   logic [2:0] p_cls = '0, s_cls = '0;
   logic [1:0] p_size = '0, s_size = '0, p_okind = '0, s_okind = '0;
   logic [RW-1:0] p_dst = '0, p_src = '0, s_dst = '0, s_src = '0;
   logic p_dmem = 1'b0, s_dmem = 1'b0;
   logic [LW-1:0] s_len = '0;

   logic          pair_valid, m_store, m_pri_agen;
   logic [1:0]    pair_grp, m_op1_kind, m_op2_kind, m_sec_unit;
   logic [RW-1:0] m_dst, m_op1_reg, m_op2_reg;

   int n_checks = 0;
   int n_fail = 0;
   exp_t sb_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   pair_classify #(.REG_W(RW), .LEN_W(LW), .SEC_LEN(1), .BYPASS_EN(1'b0)) i_pair_classify (
      .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
      .p_cls(p_cls), .p_size(p_size), .p_dst(p_dst), .p_src(p_src),
      .p_okind(p_okind), .p_dmem(p_dmem),
      .s_cls(s_cls), .s_size(s_size), .s_dst(s_dst), .s_src(s_src),
      .s_okind(s_okind), .s_dmem(s_dmem), .s_len(s_len),
      .pair_valid(pair_valid), .pair_grp(pair_grp), .m_dst(m_dst),
      .m_op1_kind(m_op1_kind), .m_op1_reg(m_op1_reg),
      .m_op2_kind(m_op2_kind), .m_op2_reg(m_op2_reg),
      .m_sec_unit(m_sec_unit), .m_store(m_store), .m_pri_agen(m_pri_agen)
   );

   function automatic desc_t mk(input logic [2:0] c, input logic [1:0] z,
                                input logic [RW-1:0] d, input logic [RW-1:0] s,
                                input logic [1:0] k, input logic m, input logic [LW-1:0] l);
      desc_t r;
      r.cls = c; r.sz = z; r.dst = d; r.src = s; r.ok = k; r.dm = m; r.len = l;
      return r;
   endfunction

   // expected group per the requirement text
   function automatic logic [1:0] model_grp(input desc_t p, input desc_t s);
      logic ok, g1, g2, g3p, g3s, haz;
      ok  = (s.len == 1) && (s.ok != 3) && !s.dm;                             // R2
      g1  = p.cls == 1 && p.sz == 2 && !p.dm && (p.ok == 0 || p.ok == 3) &&
            s.cls == 6 && s.sz == 2 && (s.ok == 0 || s.ok == 1) && s.dst == p.dst; // R3
      g2  = p.dm && p.sz != 3 && ((p.cls == 1 && p.ok == 0) || p.cls == 2) &&
            ((s.cls == 1 && s.sz == 2 && s.ok == 0) || s.cls == 4);            // R5
      g3p = !p.dm && (p.cls == 3 || (p.cls == 1 && p.sz == 2 && p.ok == 2) ||
                      p.cls == 4 || (p.cls == 2 && p.sz == 2) || p.cls == 5);  // R7
      g3s = (s.cls == 6 && s.sz == 2 && (s.ok == 0 || s.ok == 1)) ||
            (s.cls == 1 && s.sz == 2 && s.ok == 0) || s.cls == 4 ||
            (s.cls == 7 && s.sz == 2 && s.ok == 0);
      haz = (s.ok == 0 && s.src == p.dst) || ((s.cls == 6 || s.cls == 7) && s.dst == p.dst); // R8
      if (!ok) return 2'd0;
      if (g1) return 2'd1;
      if (g2) return 2'd2;
      if (g3p && g3s && !haz) return 2'd3;
      return 2'd0;
   endfunction

   task automatic send(input desc_t p, input desc_t s, input logic v, input logic f, input string tag);
      exp_t e;
      logic [1:0] g;
      @(negedge clk);
      p_cls = p.cls; p_size = p.sz; p_dst = p.dst; p_src = p.src; p_okind = p.ok; p_dmem = p.dm;
      s_cls = s.cls; s_size = s.sz; s_dst = s.dst; s_src = s.src; s_okind = s.ok; s_dmem = s.dm;
      s_len = s.len; in_valid = v; flush = f;
      g = (v && !f) ? model_grp(p, s) : 2'd0;
      e = '{v: 1'b0, g: 2'd0, dst: '0, k1: '0, r1: '0, k2: '0, r2: '0, su: '0, st: 1'b0, ag: 1'b0, tag: tag};
      if (g != 0) begin
         e.v = 1'b1; e.g = g;
         e.dst = (g == 1) ? p.dst : s.dst;
         e.k1 = p.ok; e.r1 = p.src; e.k2 = s.ok; e.r2 = s.src;
         e.su = (g == 2) ? 2'd2 : 2'd1;
         e.st = (g == 2);
         e.ag = (g == 3);
      end
      sb_q.push_back(e);
   endtask

   // monitor: compares just after each rising edge
   always @(posedge clk) begin
      #1;
      if (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         n_checks++;
         if (pair_valid !== e.v || pair_grp !== e.g) begin
            n_fail++;
            $display("FAIL %s R9 valid/group: actual %b/%0d expected %b/%0d", e.tag, pair_valid, pair_grp, e.v, e.g);
         end
         n_checks++;
         if ({m_dst, m_op1_kind, m_op1_reg, m_op2_kind, m_op2_reg, m_sec_unit, m_store, m_pri_agen} !==
             {e.dst, e.k1, e.r1, e.k2, e.r2, e.su, e.st, e.ag}) begin
            n_fail++;
            $display("FAIL %s R11 merged fields: actual %h expected %h", e.tag,
                     {m_dst, m_op1_kind, m_op1_reg, m_op2_kind, m_op2_reg, m_sec_unit, m_store, m_pri_agen},
                     {e.dst, e.k1, e.r1, e.k2, e.r2, e.su, e.st, e.ag});
         end
      end
   end

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin : main
      desc_t p, s;
      repeat (3) @(negedge clk);
      // R1: outputs zero under reset
      n_checks++;
      if ({pair_valid, pair_grp, m_dst, m_op1_kind, m_op1_reg, m_op2_kind, m_op2_reg,
           m_sec_unit, m_store, m_pri_agen} !== '0) begin
         n_fail++;
         $display("FAIL R1 reset state: actual %b expected 0", pair_valid);
      end
      rst_n = 1'b1;

      // R3 R4: move.l reg -> ALU.l quick on same register
      send(mk(1,2,4'h5,4'h2,0,0,1), mk(6,2,4'h5,4'h3,1,0,1), 1, 0, "R3_R4 load reg src");
      send(mk(1,2,4'h7,4'h9,3,0,1), mk(6,2,4'h7,4'hA,0,0,1), 1, 0, "R3_R4 load mem src");
      send(mk(1,2,4'h7,4'h9,0,0,1), mk(6,2,4'h6,4'hA,0,0,1), 1, 0, "R3 dst mismatch");
      send(mk(1,1,4'h7,4'h9,0,0,1), mk(6,2,4'h7,4'hA,0,0,1), 1, 0, "R3 word move");
      // R2: secondary eligibility
      send(mk(1,2,4'h5,4'h2,0,0,1), mk(6,2,4'h5,4'h3,1,0,2), 1, 0, "R2 long secondary");
      send(mk(1,2,4'h5,4'h2,0,0,1), mk(6,2,4'h5,4'h3,1,0,0), 1, 0, "R2 zero length");
      send(mk(1,2,4'h5,4'h2,0,0,1), mk(6,2,4'h5,4'h3,3,0,1), 1, 0, "R2 mem source");
      send(mk(3,2,4'h1,4'h2,3,0,1), mk(1,2,4'h8,4'h3,0,1,1), 1, 0, "R2 mem dest");
      // R5 R6: store pairs
      send(mk(1,0,4'h1,4'h4,0,1,1), mk(1,2,4'hC,4'hD,0,0,1), 1, 0, "R5_R6 byte store + move");
      send(mk(2,1,4'h1,4'h0,0,1,1), mk(4,2,4'hE,4'h0,2,0,1), 1, 0, "R5_R6 clear + moveq");
      send(mk(1,2,4'h1,4'h4,0,1,1), mk(1,1,4'hC,4'hD,0,0,1), 1, 0, "R5 word sec move");
      send(mk(1,2,4'h1,4'h4,2,1,1), mk(4,2,4'hC,4'h0,2,0,1), 1, 0, "R5 imm store source");
      send(mk(2,3,4'h1,4'h0,0,1,1), mk(4,2,4'hC,4'h0,2,0,1), 1, 0, "R5 reserved size");
      // R7 R8: address pairs
      send(mk(3,2,4'h8,4'h1,3,0,1), mk(6,2,4'h2,4'h3,0,0,1), 1, 0, "R7 lea + alu");
      send(mk(1,2,4'h8,4'h0,2,0,1), mk(7,2,4'h2,4'h3,0,0,1), 1, 0, "R7 move imm + cmp");
      send(mk(2,2,4'h8,4'h0,0,0,1), mk(4,2,4'h8,4'h0,2,0,1), 1, 0, "R7 clr.l + moveq same dst");
      send(mk(2,1,4'h8,4'h0,0,0,1), mk(4,2,4'h2,4'h0,2,0,1), 1, 0, "R7 clr.w refused");
      send(mk(5,2,4'h8,4'h0,1,0,1), mk(7,2,4'h8,4'h3,0,0,1), 1, 0, "R8 cmp reads dst");
      send(mk(4,2,4'h8,4'h0,2,0,1), mk(1,2,4'h2,4'h8,0,0,1), 1, 0, "R8 move reads src");
      send(mk(3,2,4'h8,4'h1,3,0,1), mk(6,2,4'h8,4'h3,1,0,1), 1, 0, "R8 alu dst equals");
      // R9 R10: idle and flush
      send(mk(1,2,4'h5,4'h2,0,0,1), mk(6,2,4'h5,4'h3,1,0,1), 0, 0, "R9 in_valid low");
      send(mk(1,2,4'h5,4'h2,0,0,1), mk(6,2,4'h5,4'h3,1,0,1), 1, 1, "R10 flush");
      send(mk(1,0,4'h1,4'h4,0,1,1), mk(1,2,4'hC,4'hD,0,0,1), 1, 1, "R10 flush store");
      send(mk(1,2,4'h5,4'h2,0,0,1), mk(6,2,4'h5,4'h3,1,0,1), 1, 0, "R9 back to back");
      // random sweep
      for (int i = 0; i < 400; i++) begin
         p = mk(3'($urandom), 2'($urandom), 4'($urandom), 4'($urandom), 2'($urandom),
                1'($urandom_range(0, 3) == 0), 2'd1);
         s = mk(3'($urandom), 2'($urandom), 4'($urandom), 4'($urandom), 2'($urandom),
                1'($urandom_range(0, 7) == 0), 2'($urandom_range(0, 3) == 0 ? $urandom : 1));
         if ($urandom_range(0, 1) == 1) s.dst = p.dst;
         send(p, s, 1'($urandom_range(0, 7) != 0), 1'($urandom_range(0, 15) == 0), "R3/R5/R7/R8 random");
      end
      repeat (3) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule